// File: doc/BRIEF.md
# Dual-Port Semaphore Token Unit

This block holds a small bank of hardware tokens that two independent ports share. Each token is a flag that at most one port can own at a time. Software on either side uses a token to claim a shared resource. It writes a request to the token and then reads the token back to learn whether the claim succeeded. Ownership is handed from one side to the other by releasing the token.

Each port has its own token select, a token index, a write strobe and a single write data bit. It also has a single readback bit. The readback is combinational from the token state, so a request written in one cycle shows its result on the readback from the next cycle on. A request that cannot be granted straight away is remembered. It is granted the moment the current owner lets go. When both ports request a free token in the same cycle, the left port wins and the right port's request waits.

Top module: `sem_token_unit`

## Requirements
- R1: After reset all eight tokens are free with nothing waiting, so a selected read of any index from either port returns 1.
- R2: A selected write of data 0 to a free token grants it to the writing port. That port reads 0 for the token from the next cycle on.
- R3: At most one port owns a token at any time. A selected read returns 0 only to the owner and returns 1 to the other port.
- R4: A selected write of data 1 by the owner releases the token. If the other port has no request waiting, the token becomes free and either port can take it.
- R5: A write of data 0 to a token held by the other port is kept as a waiting request. When the owner releases, the token passes to the waiting port, which reads 0 in the cycle after the release.
- R6: When both ports write data 0 to the same free token in one cycle, the left port gets it and the right port's request waits.
- R7: A write of data 1 from a port that does not own the token leaves the owner and any waiting request unchanged.
- R8: A write of data 0 from the port that already owns the token has no effect.
- R9: Each token index from 0 to 7 keeps its ownership independently of the others.
- R10: With its select low, a port reads 1, and its write strobe has no effect on any token.
- R11: If the owner releases a token in the same cycle that the other port requests it, the token passes to the requesting port in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| leftSel | input | 1 | Left port token select |
| leftWr | input | 1 | Left port write strobe |
| leftIdx | input | 3 | Left port token index |
| leftBit | input | 1 | Left port write data (0 request, 1 release) |
| leftRd | output | 1 | Left port readback (0 means left owns the token) |
| rightSel | input | 1 | Right port token select |
| rightWr | input | 1 | Right port write strobe |
| rightIdx | input | 3 | Right port token index |
| rightBit | input | 1 | Right port write data (0 request, 1 release) |
| rightRd | output | 1 | Right port readback (0 means right owns the token) |

## Verification
The bench uses the default build of eight tokens with a 3-bit index. At that size every token can be taken and read back in a short directed sweep, so the independence of all indices is checked in full. The random phase narrows the index to half the bank for part of the run. This makes same-token collisions, same-cycle release-and-request and waiting hand-overs happen often, and each one is compared against the cycle model.

// File: rtl/semTokPkg.sv
package semTokPkg;
  localparam int unsigned TOKEN_COUNT = 8;
  localparam int unsigned IDX_W = $clog2(TOKEN_COUNT);

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } ownerE;

  typedef struct packed {
    logic [TOKEN_COUNT-1:0] reqLeft;
    logic [TOKEN_COUNT-1:0] relLeft;
    logic [TOKEN_COUNT-1:0] reqRight;
    logic [TOKEN_COUNT-1:0] relRight;
  } strobeS;
endpackage

// File: rtl/sem_ctrl.sv
module sem_ctrl
  import semTokPkg::*;
(
  input  logic             leftSel,
  input  logic             leftWr,
  input  logic [IDX_W-1:0] leftIdx,
  input  logic             leftBit,
  input  logic             rightSel,
  input  logic             rightWr,
  input  logic [IDX_W-1:0] rightIdx,
  input  logic             rightBit,
  output strobeS           strobes
);
  logic leftWrite;
  logic rightWrite;

  assign leftWrite  = leftSel && leftWr;
  assign rightWrite = rightSel && rightWr;

  for (genvar t = 0; t < TOKEN_COUNT; t++) begin : g_dec
    logic leftHit;
    logic rightHit;
    assign leftHit  = leftWrite && (leftIdx == IDX_W'(t));
    assign rightHit = rightWrite && (rightIdx == IDX_W'(t));
    assign strobes.reqLeft[t]  = leftHit && !leftBit;
    assign strobes.relLeft[t]  = leftHit && leftBit;
    assign strobes.reqRight[t] = rightHit && !rightBit;
    assign strobes.relRight[t] = rightHit && rightBit;
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import semTokPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqLeft,
  input  logic relLeft,
  input  logic reqRight,
  input  logic relRight,
  output logic ownLeft,
  output logic ownRight
);
  ownerE owner, ownerNext;
  logic  waitLeft, waitLeftNext;
  logic  waitRight, waitRightNext;

  always_comb begin
    ownerNext     = owner;
    waitLeftNext  = waitLeft;
    waitRightNext = waitRight;
    unique case (owner)
      OWN_NONE: begin
        if (reqLeft) begin
          ownerNext     = OWN_LEFT;
          waitRightNext = reqRight;
        end else if (reqRight) begin
          ownerNext = OWN_RIGHT;
        end
      end
      OWN_LEFT: begin
        if (relLeft) begin
          ownerNext     = (waitRight || reqRight) ? OWN_RIGHT : OWN_NONE;
          waitRightNext = 1'b0;
        end else begin
          waitRightNext = waitRight || reqRight;
        end
      end
      OWN_RIGHT: begin
        if (relRight) begin
          ownerNext    = (waitLeft || reqLeft) ? OWN_LEFT : OWN_NONE;
          waitLeftNext = 1'b0;
        end else begin
          waitLeftNext = waitLeft || reqLeft;
        end
      end
      default: begin
        ownerNext     = OWN_NONE;
        waitLeftNext  = 1'b0;
        waitRightNext = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      owner     <= OWN_NONE;
      waitLeft  <= 1'b0;
      waitRight <= 1'b0;
    end else begin
      owner     <= ownerNext;
      waitLeft  <= waitLeftNext;
      waitRight <= waitRightNext;
    end
  end

  assign ownLeft  = (owner == OWN_LEFT);
  assign ownRight = (owner == OWN_RIGHT);
endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import semTokPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobeS           strobes,
  input  logic             leftSel,
  input  logic [IDX_W-1:0] leftIdx,
  input  logic             rightSel,
  input  logic [IDX_W-1:0] rightIdx,
  output logic             leftRd,
  output logic             rightRd
);
  logic [TOKEN_COUNT-1:0] ownLeftVec;
  logic [TOKEN_COUNT-1:0] ownRightVec;

  for (genvar t = 0; t < TOKEN_COUNT; t++) begin : g_cell
    sem_cell u_cell (
      .clk      (clk),
      .rstN     (rstN),
      .reqLeft  (strobes.reqLeft[t]),
      .relLeft  (strobes.relLeft[t]),
      .reqRight (strobes.reqRight[t]),
      .relRight (strobes.relRight[t]),
      .ownLeft  (ownLeftVec[t]),
      .ownRight (ownRightVec[t])
    );
  end

  assign leftRd  = !(leftSel && ownLeftVec[leftIdx]);
  assign rightRd = !(rightSel && ownRightVec[rightIdx]);
endmodule

// File: rtl/sem_token_unit.sv
module sem_token_unit
  import semTokPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             leftSel,
  input  logic             leftWr,
  input  logic [IDX_W-1:0] leftIdx,
  input  logic             leftBit,
  output logic             leftRd,
  input  logic             rightSel,
  input  logic             rightWr,
  input  logic [IDX_W-1:0] rightIdx,
  input  logic             rightBit,
  output logic             rightRd
);
  strobeS strobes;

  sem_ctrl u_ctrl (
    .leftSel  (leftSel),
    .leftWr   (leftWr),
    .leftIdx  (leftIdx),
    .leftBit  (leftBit),
    .rightSel (rightSel),
    .rightWr  (rightWr),
    .rightIdx (rightIdx),
    .rightBit (rightBit),
    .strobes  (strobes)
  );

  sem_bank u_bank (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .leftSel  (leftSel),
    .leftIdx  (leftIdx),
    .rightSel (rightSel),
    .rightIdx (rightIdx),
    .leftRd   (leftRd),
    .rightRd  (rightRd)
  );
endmodule

// File: rtl/sem_token_checker.sv
module sem_token_checker
  import semTokPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             leftSel,
  input logic             leftWr,
  input logic [IDX_W-1:0] leftIdx,
  input logic             leftBit,
  input logic             leftRd,
  input logic             rightSel,
  input logic             rightWr,
  input logic [IDX_W-1:0] rightIdx,
  input logic             rightBit,
  input logic             rightRd
);
  // R10: a deselected port always reads 1
  p_deselect_left_r10: assert property (@(posedge clk) disable iff (!rstN)
    !leftSel |-> leftRd);
  p_deselect_right_r10: assert property (@(posedge clk) disable iff (!rstN)
    !rightSel |-> rightRd);

  // R3: both ports never read ownership of the same token
  p_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    (leftSel && rightSel && leftIdx == rightIdx) |-> (leftRd || rightRd));

  // R2: request on a token both sides see as free is granted
  p_grant_free_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(leftSel && rightSel && leftIdx == rightIdx && leftRd && rightRd
           && leftWr && !leftBit)
     && leftSel && leftIdx == $past(leftIdx)) |-> !leftRd);

  // R6: simultaneous requests on a free token go to the left port
  p_tie_left_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(leftSel && rightSel && leftIdx == rightIdx && leftRd && rightRd
           && leftWr && !leftBit && rightWr && !rightBit)
     && rightSel && rightIdx == $past(rightIdx)) |-> rightRd);

  // R7 and R8: the left owner keeps its token until it writes 1 itself
  p_keep_left_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(leftSel && !leftRd && !(leftWr && leftBit))
     && leftSel && leftIdx == $past(leftIdx)) |-> !leftRd);
  p_keep_right_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rightSel && !rightRd && !(rightWr && rightBit))
     && rightSel && rightIdx == $past(rightIdx)) |-> !rightRd);
endmodule

bind sem_token_unit sem_token_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .leftSel  (leftSel),
  .leftWr   (leftWr),
  .leftIdx  (leftIdx),
  .leftBit  (leftBit),
  .leftRd   (leftRd),
  .rightSel (rightSel),
  .rightWr  (rightWr),
  .rightIdx (rightIdx),
  .rightBit (rightBit),
  .rightRd  (rightRd)
);

// File: tb/sim_sem_token_unit.sv
module sim_sem_token_unit;
  import semTokPkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN;
  logic leftSel, leftWr, leftBit, rightSel, rightWr, rightBit;
  logic [IDX_W-1:0] leftIdx, rightIdx;
  logic leftRd, rightRd;

  sem_token_unit u0 (
    .clk(clk), .rstN(rstN),
    .leftSel(leftSel), .leftWr(leftWr), .leftIdx(leftIdx), .leftBit(leftBit), .leftRd(leftRd),
    .rightSel(rightSel), .rightWr(rightWr), .rightIdx(rightIdx), .rightBit(rightBit), .rightRd(rightRd)
  );

  // model: 0 free, 1 left owns, 2 right owns
  int    holder[TOKEN_COUNT];
  bit    waitL[TOKEN_COUNT];
  bit    waitR[TOKEN_COUNT];
  int    errors = 0;
  int    checks = 0;
  string curReq = "R1";
  bit    done = 0;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check_bit(string side, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s readback: actual=%0b expected=%0b", curReq, side, act, exp);
    end
  endtask

  function automatic logic expect_rd(int who, bit sel, int idx);
    return !(sel && holder[idx] == who);
  endfunction

  task automatic model_update(bit lS, bit lW, int lI, bit lB, bit rS, bit rW, int rI, bit rB);
    for (int t = 0; t < TOKEN_COUNT; t++) begin
      bit askL  = lS && lW && !lB && lI == t;
      bit dropL = lS && lW && lB && lI == t;
      bit askR  = rS && rW && !rB && rI == t;
      bit dropR = rS && rW && rB && rI == t;
      if (holder[t] == 0) begin
        if (askL) begin holder[t] = 1; waitR[t] = askR; end
        else if (askR) holder[t] = 2;
      end else if (holder[t] == 1) begin
        if (dropL) begin holder[t] = (waitR[t] || askR) ? 2 : 0; waitR[t] = 0; end
        else if (askR) waitR[t] = 1;
      end else begin
        if (dropR) begin holder[t] = (waitL[t] || askL) ? 1 : 0; waitL[t] = 0; end
        else if (askL) waitL[t] = 1;
      end
    end
  endtask

  task automatic step(bit lS, bit lW, int lI, bit lB, bit rS, bit rW, int rI, bit rB);
    @(negedge clk);
    leftSel = lS; leftWr = lW; leftIdx = IDX_W'(lI); leftBit = lB;
    rightSel = rS; rightWr = rW; rightIdx = IDX_W'(rI); rightBit = rB;
    #2;
    check_bit("left", leftRd, expect_rd(1, lS, lI));
    check_bit("right", rightRd, expect_rd(2, rS, rI));
    @(posedge clk);
    model_update(lS, lW, lI, lB, rS, rW, rI, rB);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    for (int t = 0; t < TOKEN_COUNT; t++) begin holder[t] = 0; waitL[t] = 0; waitR[t] = 0; end
    rstN = 1'b0;
    leftSel = 0; leftWr = 0; leftIdx = '0; leftBit = 0;
    rightSel = 0; rightWr = 0; rightIdx = '0; rightBit = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    curReq = "R1";
    for (int t = 0; t < TOKEN_COUNT; t++) step(1, 0, t, 0, 1, 0, t, 0);

    curReq = "R2";
    step(1, 1, 3, 0, 1, 1, 5, 0);
    step(1, 0, 3, 0, 1, 0, 5, 0);

    curReq = "R3";
    step(1, 0, 5, 0, 1, 0, 3, 0);
    step(1, 0, 3, 0, 1, 1, 3, 0);
    step(1, 0, 3, 0, 1, 0, 3, 0);

    curReq = "R5";
    step(1, 1, 3, 1, 1, 0, 3, 0);
    step(1, 0, 3, 0, 1, 0, 3, 0);

    curReq = "R4";
    step(0, 0, 0, 0, 1, 1, 5, 1);
    step(1, 0, 5, 0, 1, 0, 5, 0);
    step(1, 1, 5, 0, 0, 0, 0, 0);
    step(1, 0, 5, 0, 1, 0, 5, 0);

    curReq = "R6";
    step(1, 1, 6, 0, 1, 1, 6, 0);
    step(1, 0, 6, 0, 1, 0, 6, 0);
    step(1, 1, 6, 1, 0, 0, 0, 0);
    step(1, 0, 6, 0, 1, 0, 6, 0);

    curReq = "R7";
    step(0, 0, 0, 0, 1, 1, 5, 1);
    step(1, 0, 5, 0, 1, 0, 5, 0);

    curReq = "R8";
    step(1, 1, 5, 0, 1, 0, 5, 0);
    step(1, 0, 5, 0, 1, 0, 5, 0);

    curReq = "R11";
    step(1, 1, 6, 0, 1, 1, 6, 1);
    step(1, 0, 6, 0, 1, 0, 6, 0);

    curReq = "R10";
    step(0, 1, 2, 0, 0, 1, 2, 0);
    step(1, 0, 2, 0, 1, 0, 2, 0);
    step(0, 1, 5, 1, 0, 1, 6, 1);
    step(1, 0, 5, 0, 1, 0, 6, 0);

    curReq = "R9";
    for (int t = 0; t < TOKEN_COUNT; t++) step(1, 1, t, 1, 1, 1, t, 1);
    for (int t = 0; t < TOKEN_COUNT; t++) step(1, 1, t, 0, 0, 0, 0, 0);
    for (int t = 0; t < TOKEN_COUNT; t++) step(1, 0, t, 0, 1, 1, t, 0);
    for (int t = 0; t < TOKEN_COUNT; t++) step(1, 0, t, 0, 1, 0, t, 0);

    for (int n = 0; n < 3000; n++) begin
      int span = (n % 2 == 0) ? TOKEN_COUNT / 2 : TOKEN_COUNT;
      step(($urandom % 4) != 0, $urandom % 2, int'($urandom % span), $urandom % 2,
           ($urandom % 4) != 0, $urandom % 2, int'($urandom % span), $urandom % 2);
    end

    done = 1;
    finish_run();
  end
endmodule